// File: doc/BRIEF.md
# Stuck Interrupt Re-Trigger Monitor

This block sits between the level-sensitive interrupt line of a storage host controller and the edge-sensitive message-interrupt request input of a PCIe bridge. Each fresh assertion of the source interrupt reaches the bridge as a rising edge. The bridge turns that edge into one MSI write. If software misses that message, the source line stays high and no further edge would ever appear.

To recover from this, the block times how long the synchronized source has stayed high. The limit is 100 ms by default and is derived from a clock-frequency parameter. When the limit is reached, the output is pulled low for a short gap and then driven high again, so the bridge sees a new edge and sends the message again. The timer restarts after each re-trigger. A line that stays stuck is therefore re-announced once per period. When the source drops, everything returns to idle and the output goes low.

Top module: `irq_refire`

## Requirements
- R1: The source input passes through a two-flop synchronizer. From idle, a rising source seen before clock edge k makes `irq_req_o` high after edge k+2, so it is high when sampled after the third edge.
- R2: When the source falls, `irq_req_o` is low after the third clock edge, whatever the state was. The hold timer is cleared, so the next assertion is given the full timeout.
- R3: With the source held high, `irq_req_o` stays high for exactly HOLD_CYCLES = (CLK_HZ/1000)*TIMEOUT_MS consecutive cycles and then falls.
- R4: After a timeout fall, and while the source stays high, `irq_req_o` stays low for exactly GAP_CYCLES cycles. Values below 2 are raised to 2. It then rises again, which is a new edge.
- R5: A source that stays stuck high gives a rising edge on `irq_req_o` every HOLD_CYCLES+GAP_CYCLES cycles. Each high phase is a full HOLD_CYCLES long.
- R6: A source deassertion takes priority over the end of a gap or of a hold in the same cycle. A source that falls during a gap gives no further rising edge.
- R7: While `rst_n` is low, `irq_req_o` is low and both timers are cleared. Reset is applied asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq_i | input | 1 | Level interrupt from the host controller, asynchronous |
| irq_req_o | output | 1 | Edge-carrying interrupt request to the bridge |

## Verification
Two events can land in the same cycle: the gap counter finishing, and the synchronized source dropping. The bench provokes this with a source pulse that lasts exactly one hold time plus one gap. The synchronized line then falls in the last gap cycle. It also provokes the hold expiry falling together with the source, using a pulse of exactly one hold time. For each pulse the bench counts rising edges and high cycles on the output. A design that let the gap end win would show a second edge and an extra high cycle.

// File: rtl/irq_refire_pkg.sv
package irq_refire_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_GAP  = 2'd2
  } refire_st_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_span_timer.sv
module irq_span_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (done_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the count never passes the terminal value
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2: a stopped timer is back at zero one cycle later
  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/irq_refire_fsm.sv
module irq_refire_fsm
  import irq_refire_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_s_i,
  input  logic hold_done_i,
  input  logic gap_done_i,
  output logic hold_run_o,
  output logic gap_run_o,
  output logic req_o
);
  refire_st_e state_q;
  refire_st_e state_d;
  logic       req_q;
  logic       req_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (irq_s_i) state_d = ST_HIGH;
      ST_HIGH: begin
        if (!irq_s_i)         state_d = ST_IDLE;
        else if (hold_done_i) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (!irq_s_i)        state_d = ST_IDLE;
        else if (gap_done_i) state_d = ST_HIGH;
      end
      default: state_d = ST_IDLE;
    endcase
    req_d = (state_d == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign hold_run_o = (state_q == ST_HIGH);
  assign gap_run_o  = (state_q == ST_GAP);
  assign req_o      = req_q;

  // R1: a synchronized rise from idle raises the request on the next edge
  assert_rise_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_s_i) |=> req_q);

  // R2: a low synchronized source forces the request low on the next edge
  assert_drop_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_s_i |=> !req_q);

  // R4: a re-trigger gap keeps the request low for at least two cycles
  assert_gap_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_q) && irq_s_i) |=> !req_q);
endmodule

// File: rtl/irq_refire.sv
module irq_refire #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TIMEOUT_MS = 100,
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_irq_i,
  output logic irq_req_o
);
  localparam int HOLD_CYCLES = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int GAP_LEN     = (GAP_CYCLES < 2) ? 2 : GAP_CYCLES;

  logic rst_n_sync;
  logic irq_s;
  logic hold_run;
  logic gap_run;
  logic hold_done;
  logic gap_done;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_sync2 #(.STAGES(2)) u_src_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   (src_irq_i),
    .q_o   (irq_s)
  );

  irq_span_timer #(.LIMIT(HOLD_CYCLES)) u_hold_timer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .run_i  (hold_run),
    .done_o (hold_done)
  );

  irq_span_timer #(.LIMIT(GAP_LEN)) u_gap_timer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .run_i  (gap_run),
    .done_o (gap_done)
  );

  irq_refire_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .irq_s_i     (irq_s),
    .hold_done_i (hold_done),
    .gap_done_i  (gap_done),
    .hold_run_o  (hold_run),
    .gap_run_o   (gap_run),
    .req_o       (irq_req_o)
  );

  // R1: every output edge is backed by a high synchronized source
  assert_rise_needs_src_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq_req_o) |-> $past(irq_s));

  // R6: the gap end never raises the output once the source is gone
  assert_no_refire_after_drop_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (gap_run && !irq_s) |=> !irq_req_o);
endmodule

// File: tb/irq_refire_bench.sv
module irq_refire_bench;
  localparam int CLK_HZ = 20_000;
  localparam int TMO_MS = 100;
  localparam int GAP    = 3;
  localparam int NVEC   = 8;

  // {source high cycles, expected rising edges, expected output high cycles}
  // hold = 2000 cycles, gap = 3 cycles
  localparam int VEC [NVEC][3] = '{
    '{10,   1, 10},
    '{2000, 1, 2000},
    '{2001, 1, 2000},
    '{2002, 1, 2000},
    '{2003, 1, 2000},
    '{2004, 2, 2001},
    '{4100, 3, 4094},
    '{1,    1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src = 1'b0;
  logic irq_req;

  int n_checks = 0;
  int n_fail = 0;
  int n_edges = 0;
  int n_high = 0;
  logic prev_req = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_refire #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS), .GAP_CYCLES(GAP)) u_irq_refire (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_irq_i (src),
    .irq_req_o (irq_req)
  );

  always @(negedge clk) begin
    if (irq_req && !prev_req) n_edges++;
    if (irq_req) n_high++;
    prev_req <= irq_req;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R7: output low while reset is held, even with the source high
    src = 1'b1;
    wait_n(5);
    check("R7 reset holds output low", int'(irq_req), 0);
    src = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
    check("R7 output low after release", int'(irq_req), 0);

    // R1 / R2: latency through the synchronizer and state register
    src = 1'b1;
    wait_n(2);
    check("R1 not yet high after two edges", int'(irq_req), 0);
    wait_n(1);
    check("R1 high after third edge", int'(irq_req), 1);
    wait_n(20);
    src = 1'b0;
    wait_n(2);
    check("R2 still high after two edges", int'(irq_req), 1);
    wait_n(1);
    check("R2 low after third edge", int'(irq_req), 0);
    wait_n(10);

    // R3 R4 R5 R6: vector table of pulse lengths
    for (int v = 0; v < NVEC; v++) begin
      int e0;
      int h0;
      e0 = n_edges;
      h0 = n_high;
      src = 1'b1;
      wait_n(VEC[v][0]);
      src = 1'b0;
      wait_n(12);
      check($sformatf("R3/R5/R6 edges, pulse %0d", VEC[v][0]), n_edges - e0, VEC[v][1]);
      check($sformatf("R3/R4/R6 high cycles, pulse %0d", VEC[v][0]), n_high - h0, VEC[v][2]);
    end

    // R4: gap length measured directly on a stuck source
    src = 1'b1;
    wait_n(3 + 2000);
    check("R4 low at start of gap", int'(irq_req), 0);
    wait_n(GAP - 1);
    check("R4 low at end of gap", int'(irq_req), 0);
    wait_n(1);
    check("R4 high again after gap", int'(irq_req), 1);

    // R7: reset in the middle of activity, then full restart
    wait_n(50);
    rst_n = 1'b0;
    #1;
    check("R7 async reset drops output", int'(irq_req), 0);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(10);
    check("R7 restarts with source still high", int'(irq_req), 1);
    src = 1'b0;
    wait_n(10);
    check("R2 low after final release", int'(irq_req), 0);

    done = 1'b1;
    finish_run();
  end
endmodule